// File: doc/BRIEF.md
# Successive-Approximation ADC Control Unit

This block is the register-mapped controller of an 8-channel, 8-bit successive-approximation converter in a small microcontroller. Software reaches it through three byte registers: a read-only result register, a control register and a clock-setting register. The control register holds the channel select, a port configuration code and two bits that run the converter, START and the end-of-conversion flag.

A conversion begins with a START pulse: software writes START high and then low. While START stays high the sequencer is held in reset and the end flag reads 1. The falling edge starts eight successive-approximation steps, MSB first. Each step lasts one converter-clock period. The unit presents a trial code to an external DAC/comparator pair and keeps the trial bit when the comparator reports input ≥ trial. At the last step the code is loaded into the result register, the end flag clears and an interrupt request flag is set. The interrupt output is that flag gated by an enable input.

Top module: `adc_ctl_regs`

## Requirements
- R1: After reset the result (0x21), control (0x22) and clock-setting (0x23) registers read 0x00, and `irq`, `dac_code` and `analog_en` are 0.
- R2: The control register reads back as {START[7], EOC[6], CFG[5:3], CH[2:0]}. `ch_sel` follows CH, and a read of an unmapped address returns 0x00.
- R3: `analog_en[i]` is 1 exactly when i < CFG, so code 0 makes every line digital and code 7 makes lines 0..6 analog.
- R4: A write that takes START from 0 to 1 sets EOC to 1. While START is 1 no conversion runs and `dac_code` is 0x00.
- R5: A write that takes START from 1 to 0 starts a conversion. The result register receives the largest code that the comparator (input ≥ trial) accepts, and EOC clears on the same edge.
- R6: Clock-setting bits [1:0] select a step length of 2, 8 or 32 system clocks for codes 0, 1 and 2, and 32 for code 3. A conversion takes exactly 8 steps from the START falling-edge write. Bit 7 is stored and read back but has no effect on timing.
- R7: Completion sets the interrupt flag, which reads back as clock-setting bit 4, and `irq` = flag AND `irq_en`. Writing 0 to bit 4 clears the flag. Writing 1 has no effect.
- R8: Writing START=1 during a conversion aborts it: EOC reads 1, no completion occurs and the result register is unchanged.
- R9: Writes to the result register are ignored, and the EOC bit cannot be written by software. The result holds its value until the next completion.
- R10: During the first step of a conversion `dac_code` is 0x80 (MSB trial).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address (combinational read) |
| rd_data | output | 8 | Read data |
| cmp_in | input | 1 | Comparator: 1 when analog input ≥ `dac_code` |
| dac_code | output | 8 | Trial code driven to the DAC |
| ch_sel | output | 3 | Selected analog channel |
| analog_en | output | 8 | Per-line analog mode (digital I/O and pull-up off) |
| irq_en | input | 1 | Converter interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a START rewrite that lands partway through the successive-approximation steps. It must abort the run and leave both the old result and the cleared interrupt flag alone. The stimulus starts a conversion, waits a few step lengths and rewrites START high. It then idles far longer than any conversion and checks that nothing completed. Randomized runs sweep the analog value, clock code, channel, configuration code and interrupt enable, and they time each conversion edge by edge.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
   typedef enum logic [1:0] {
      CLK_FAST = 2'b00,
      CLK_MID  = 2'b01,
      CLK_SLOW = 2'b10,
      CLK_ALT  = 2'b11
   } clk_code_e;

   function automatic int unsigned div_of(input logic [1:0] code,
                                          input int unsigned d_fast,
                                          input int unsigned d_mid,
                                          input int unsigned d_slow);
      case (clk_code_e'(code))
         CLK_FAST: return d_fast;
         CLK_MID:  return d_mid;
         default:  return d_slow;
      endcase
   endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int unsigned DIV_FAST = 2,
   parameter int unsigned DIV_MID  = 8,
   parameter int unsigned DIV_SLOW = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   import adc_ctl_pkg::*;
   localparam int unsigned CNT_W = $clog2(DIV_SLOW + 1);

   if (DIV_FAST < 2 || DIV_MID < DIV_FAST || DIV_SLOW < DIV_MID) begin : g_bad_div
      $error("adc_clk_div: dividers must be >= 2 and non-decreasing");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   always_comb lim = CNT_W'(div_of(sel, DIV_FAST, DIV_MID, DIV_SLOW) - 1);
   assign tick = run && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         abort,
   input  logic         tick,
   input  logic         cmp_in,
   output logic         busy,
   output logic [W-1:0] dac_code,
   output logic         done,
   output logic [W-1:0] result_nxt
);
   if (W < 2) begin : g_bad_w
      $error("adc_sar_seq: width must be at least 2");
   end

   logic [W-1:0] acc_q;
   logic [W-1:0] bit_q;
   logic [W-1:0] trial;

   assign trial      = acc_q | bit_q;
   assign dac_code   = busy ? trial : '0;
   assign done       = busy && tick && bit_q[0] && !abort;
   assign result_nxt = cmp_in ? trial : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         acc_q <= '0;
         bit_q <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         acc_q <= '0;
         bit_q <= '0;
      end else if (go) begin
         busy  <= 1'b1;
         acc_q <= '0;
         bit_q <= {1'b1, {(W-1){1'b0}}};
      end else if (busy && tick) begin
         acc_q <= result_nxt;
         bit_q <= bit_q >> 1;
         if (bit_q[0]) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_cfg_decode.sv
module adc_cfg_decode #(
   parameter int unsigned CFG_W     = 3,
   parameter int unsigned N_LINES   = 8,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [CFG_W-1:0]   cfg,
   output logic [N_LINES-1:0] analog_en
);
   if (N_LINES < (1 << CFG_W) - 1) begin : g_bad_lines
      $error("adc_cfg_decode: too few lines for the configuration code");
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      if (LOW_FIRST) begin : g_low
         assign analog_en[i] = (int'(cfg) > i);
      end else begin : g_high
         assign analog_en[i] = (int'(cfg) >= N_LINES - i);
      end
   end
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CH_W      = 3,
   parameter int unsigned CFG_W     = 3,
   parameter int unsigned N_LINES   = 8,
   parameter int unsigned DIV_FAST  = 2,
   parameter int unsigned DIV_MID   = 8,
   parameter int unsigned DIV_SLOW  = 32,
   parameter logic [7:0]  A_RESULT  = 8'h21,
   parameter logic [7:0]  A_CTRL    = 8'h22,
   parameter logic [7:0]  A_CLKSET  = 8'h23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cmp_in,
   output logic [DATA_W-1:0] dac_code,
   output logic [CH_W-1:0]   ch_sel,
   output logic [N_LINES-1:0] analog_en,
   input  logic              irq_en,
   output logic              irq
);
   localparam int unsigned START_B = DATA_W - 1;
   localparam int unsigned EOC_B   = DATA_W - 2;
   localparam int unsigned CFG_LO  = CH_W;
   localparam int unsigned TEST_B  = DATA_W - 1;
   localparam int unsigned FLAG_B  = 4;

   if (CH_W + CFG_W > DATA_W - 2) begin : g_bad_layout
      $error("adc_ctl_regs: control fields overflow the register");
   end
   if (DATA_W < 8 || ADDR_W < 8) begin : g_bad_bus
      $error("adc_ctl_regs: bus narrower than the register map");
   end

   logic              start_q, eoc_q, test_q, flag_q;
   logic [CH_W-1:0]   ch_q;
   logic [CFG_W-1:0]  cfg_q;
   logic [1:0]        clk_sel_q;
   logic [DATA_W-1:0] result_q;

   logic wr_ctrl, wr_clk, start_rise, start_fall;
   logic seq_busy, seq_done, step_tick;
   logic [DATA_W-1:0] seq_result;

   assign wr_ctrl    = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_clk     = wr_en && (wr_addr == ADDR_W'(A_CLKSET));
   assign start_rise = wr_ctrl && !start_q &&  wr_data[START_B];
   assign start_fall = wr_ctrl &&  start_q && !wr_data[START_B];

   adc_clk_div #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_div (
      .clk(clk), .rst_n(rst_n), .run(seq_busy), .sel(clk_sel_q), .tick(step_tick)
   );

   adc_sar_seq #(.W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(start_fall), .abort(start_rise),
      .tick(step_tick), .cmp_in(cmp_in), .busy(seq_busy), .dac_code(dac_code),
      .done(seq_done), .result_nxt(seq_result)
   );

   adc_cfg_decode #(.CFG_W(CFG_W), .N_LINES(N_LINES), .LOW_FIRST(1'b1)) u_dec (
      .cfg(cfg_q), .analog_en(analog_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= 1'b0;
         eoc_q     <= 1'b0;
         ch_q      <= '0;
         cfg_q     <= '0;
         clk_sel_q <= '0;
         test_q    <= 1'b0;
         flag_q    <= 1'b0;
         result_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            start_q <= wr_data[START_B];
            ch_q    <= wr_data[CH_W-1:0];
            cfg_q   <= wr_data[CFG_LO +: CFG_W];
         end
         if (start_rise)    eoc_q <= 1'b1;
         else if (seq_done) eoc_q <= 1'b0;
         if (wr_clk) begin
            clk_sel_q <= wr_data[1:0];
            test_q    <= wr_data[TEST_B];
         end
         if (seq_done) begin
            flag_q   <= 1'b1;
            result_q <= seq_result;
         end else if (wr_clk) begin
            flag_q   <= flag_q & wr_data[FLAG_B];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_RESULT)) begin
         rd_data = result_q;
      end else if (rd_addr == ADDR_W'(A_CTRL)) begin
         rd_data[START_B]            = start_q;
         rd_data[EOC_B]              = eoc_q;
         rd_data[CFG_LO +: CFG_W]    = cfg_q;
         rd_data[CH_W-1:0]           = ch_q;
      end else if (rd_addr == ADDR_W'(A_CLKSET)) begin
         rd_data[TEST_B] = test_q;
         rd_data[FLAG_B] = flag_q;
         rd_data[1:0]    = clk_sel_q;
      end
   end

   assign ch_sel = ch_q;
   assign irq    = flag_q & irq_en;
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CFG_W   = 3,
   parameter int unsigned N_LINES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_q,
   input logic               eoc_q,
   input logic               busy,
   input logic               done,
   input logic               flag_q,
   input logic [DATA_W-1:0]  dac_code,
   input logic [DATA_W-1:0]  result_q,
   input logic [CFG_W-1:0]   cfg_q,
   input logic [N_LINES-1:0] analog_en
);
   p_hold_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> !busy);
   p_idle_dac_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_code == '0));
   p_done_clears_eoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!eoc_q && !busy));
   p_done_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> flag_q);
   p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(result_q));
   p_msb_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (dac_code == {1'b1, {(DATA_W-1){1'b0}}}));
   p_cfg_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(analog_en) == int'(cfg_q));
endmodule

bind adc_ctl_regs adc_ctl_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W), .N_LINES(N_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_q(start_q), .eoc_q(eoc_q), .busy(seq_busy),
   .done(seq_done), .flag_q(flag_q), .dac_code(dac_code), .result_q(result_q),
   .cfg_q(cfg_q), .analog_en(analog_en)
);

// File: tb/adc_ctl_regs_tb.sv
`timescale 1ns/1ps
module adc_ctl_regs_tb;
   localparam logic [7:0] A_RES = 8'h21, A_CTL = 8'h22, A_CLK = 8'h23;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0;
   logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data, dac_code, analog_en;
   logic [2:0] ch_sel;
   logic irq_en = 0, irq, cmp_in;
   logic [7:0] analog_val = 0;
   int n_chk = 0, n_bad = 0;
   int wd = 0;

   always #2 clk = ~clk;
   assign cmp_in = (analog_val >= dac_code);

   adc_ctl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cmp_in(cmp_in), .dac_code(dac_code),
      .ch_sel(ch_sel), .analog_en(analog_en), .irq_en(irq_en), .irq(irq)
   );

   function automatic int exp_div(input logic [1:0] s);
      return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
   endfunction
   function automatic logic [7:0] exp_mask(input logic [2:0] c);
      logic [7:0] m = '0;
      for (int i = 0; i < 8; i++) m[i] = (i < c);
      return m;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      rd_addr = a; #0.1; d = rd_data;
   endtask

   task automatic run_conv(input logic [7:0] val, input logic [1:0] sel, input logic tbit,
                           input logic [2:0] ch, input logic [2:0] cfg, input logic ien);
      logic [7:0] r;
      int cnt = 0;
      analog_val = val; irq_en = ien;
      wr(A_CLK, {tbit, 5'b0, sel});
      rd(A_CLK, r); chk("R7 flag cleared by writing 0", int'(r), int'({tbit, 5'b0, sel}));
      chk("R7 irq low after clear", int'(irq), 0);
      wr(A_CTL, {2'b10, cfg, ch});
      rd(A_CTL, r); chk("R4 START rise sets EOC", int'(r), int'({2'b11, cfg, ch}));
      chk("R4 dac idle while START high", int'(dac_code), 0);
      chk("R2 ch_sel", int'(ch_sel), int'(ch));
      chk("R3 analog_en", int'(analog_en), int'(exp_mask(cfg)));
      wr(A_CTL, {2'b00, cfg, ch});
      rd_addr = A_CTL;
      forever begin
         @(posedge clk); #1; cnt++;
         if (cnt == 1) chk("R10 MSB trial first", int'(dac_code), 8'h80);
         if (!rd_data[6] || cnt > 1000) break;
      end
      chk("R6 conversion length", cnt, 8 * exp_div(sel));
      rd(A_RES, r); chk("R5 result", int'(r), int'(val));
      rd(A_CLK, r); chk("R7 flag set", int'(r[4]), 1);
      chk("R7 irq gated by enable", int'(irq), int'(ien));
   endtask

   initial begin
      while (wd < 200000) begin @(posedge clk); wd++; end
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic [7:0] keep;
      void'($urandom(32'h5A3C_0917));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      rd(A_RES, r); chk("R1 result reset", int'(r), 0);
      rd(A_CTL, r); chk("R1 ctrl reset", int'(r), 0);
      rd(A_CLK, r); chk("R1 clkset reset", int'(r), 0);
      chk("R1 irq reset", int'(irq), 0);
      chk("R1 dac reset", int'(dac_code), 0);
      chk("R1 analog_en reset", int'(analog_en), 0);
      rd(8'h40, r); chk("R2 unmapped read zero", int'(r), 0);

      for (int c = 0; c < 8; c++) begin
         wr(A_CTL, {2'b00, 3'(c), 3'(7 - c)});
         chk("R3 decode sweep", int'(analog_en), int'(exp_mask(3'(c))));
         rd(A_CTL, r); chk("R2 ctrl readback", int'(r), int'({2'b00, 3'(c), 3'(7 - c)}));
      end

      run_conv(8'h00, 2'd0, 1'b0, 3'd0, 3'd0, 1'b1);
      run_conv(8'hFF, 2'd3, 1'b1, 3'd7, 3'd7, 1'b1);
      run_conv(8'h80, 2'd1, 1'b0, 3'd2, 3'd3, 1'b0);
      run_conv(8'h7F, 2'd2, 1'b1, 3'd5, 3'd1, 1'b1);

      for (int t = 0; t < 24; t++)
         run_conv(8'($urandom), 2'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 1'($urandom));

      // R7: writing 1 to the flag bit does not set it
      wr(A_CLK, 8'h00); wr(A_CLK, 8'h10);
      rd(A_CLK, r); chk("R7 write 1 no effect", int'(r[4]), 0);

      // R9: result and EOC not writable
      rd(A_RES, keep);
      wr(A_RES, ~keep);
      rd(A_RES, r); chk("R9 result write ignored", int'(r), int'(keep));
      wr(A_CTL, 8'h40);
      rd(A_CTL, r); chk("R9 EOC write ignored", int'(r), 0);

      // R8: abort mid-conversion
      irq_en = 1; analog_val = ~keep;
      wr(A_CLK, 8'h01);
      wr(A_CTL, 8'h80); wr(A_CTL, 8'h00);
      repeat (20) @(posedge clk);
      wr(A_CTL, 8'h80);
      rd(A_CTL, r); chk("R8 EOC set by abort", int'(r[6]), 1);
      repeat (300) @(posedge clk); #1;
      rd(A_RES, r); chk("R8 result unchanged", int'(r), int'(keep));
      rd(A_CLK, r); chk("R8 no completion flag", int'(r[4]), 0);
      chk("R8 dac idle after abort", int'(dac_code), 0);
      chk("R8 irq quiet", int'(irq), 0);
      run_conv(~keep, 2'd1, 1'b0, 3'd1, 3'd4, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule